// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. The word is cut into 4-bit slices. Each slice makes its own sum bits with a local carry chain. It also reports two active-low flags for its group: whether it creates a carry on its own, and whether it would pass an incoming carry through.

A four-group lookahead unit takes four of those flag pairs and an active-high carry-in. It returns the three carries that enter slices 1 to 3 and a combined active-low flag pair for all four slices. Slice 0 takes the carry-in directly. One lookahead unit and its four slices form a 16-bit section. Sections are chained, and the carry leaving one section feeds the next. The default 32-bit width uses two sections.

Setting the width to 28 drops the most significant slice. Its lookahead inputs are then tied so that the missing group neither creates nor blocks a carry. The combined flag pair of the whole word is brought out so that a further lookahead level can use it.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, with the operands taken as unsigned.
- R2: `cout` equals bit WIDTH of `a + b + cin`.
- R3: `blk_g_n` is 0 (active low) exactly when `a + b` with no carry-in reaches 2^WIDTH or more. Otherwise it is 1.
- R4: `blk_p_n` is 0 (active low) exactly when every bit of `a | b` is 1. Otherwise it is 1.
- R5: `cout` equals `(!blk_g_n) | ((!blk_p_n) & cin)` for every input.
- R6: A carry produced in the lower 16-bit section reaches the upper section. For example, `0x0000FFFF + 1` gives `0x00010000`.
- R7: With WIDTH = 28, the adder works on 28-bit operands. `cout` is then bit 28 of the sum, and R3 and R4 apply over 28 bits.
- R8: Inside every section, the carry that the lookahead unit sends into slice i+1 matches the carry that slice i makes with its own local chain. The section carry-out matches the local carry of its top slice.
- R9: WIDTH must be a positive multiple of 4. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0, active high |
| sum | output | WIDTH | Low WIDTH bits of the sum |
| cout | output | 1 | Carry out of the top bit, active high |
| blk_g_n | output | 1 | Whole-word carry-generate flag, active low |
| blk_p_n | output | 1 | Whole-word carry-propagate flag, active low |

## Verification
The bench builds two copies side by side. One uses the default WIDTH of 32, which exercises two full sections and the carry rippling between them. The other uses WIDTH of 28, which exercises a section with a padded fourth group position. That position must neither create nor block a carry, which shows up in `cout`, `blk_g_n` and `blk_p_n`. Both copies receive the same stimulus: all-ones plus one, zero plus zero, alternating bit patterns and carries that cross slice and section boundaries, followed by a long run of random operands. Every result is compared against plain integer arithmetic.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int SLICE_W   = 4;
  localparam int GROUPS_N  = 4;
  localparam int SECTION_W = SLICE_W * GROUPS_N;

  // Active-low group flag pair.
  typedef struct packed {
    logic g_n;
    logic p_n;
  } grp_pg_t;

  // Neutral element: no generate, full propagate.
  localparam grp_pg_t PG_IDENTITY = '{g_n: 1'b1, p_n: 1'b0};

  // Combine a more significant pair (hi) with a less significant pair (lo).
  function automatic grp_pg_t pg_merge(input grp_pg_t hi, input grp_pg_t lo);
    grp_pg_t r;
    r.g_n = ~((~hi.g_n) | ((~hi.p_n) & (~lo.g_n)));
    r.p_n = ~((~hi.p_n) & (~lo.p_n));
    return r;
  endfunction

endpackage

// File: rtl/cla_slice4.sv
module cla_slice4
  import cla_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         g_n,
  output logic         p_n,
  output logic         c_local
);

  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W:0]   chain;
  logic         grp_g;

  assign bit_g = a & b;
  assign bit_p = a | b;

  // Local ripple chain for the sum bits.
  always_comb begin
    chain[0] = cin;
    for (int i = 0; i < W; i++) begin
      chain[i+1] = bit_g[i] | (bit_p[i] & chain[i]);
    end
  end

  assign sum     = a ^ b ^ chain[W-1:0];
  assign c_local = chain[W];

  // Group flags, built without the carry-in.
  always_comb begin
    grp_g = bit_g[0];
    for (int i = 1; i < W; i++) begin
      grp_g = bit_g[i] | (bit_p[i] & grp_g);
    end
  end

  assign g_n = ~grp_g;
  assign p_n = ~(&bit_p);

  always_comb begin
    if (!g_n) begin
      AST_SLICE_GEN_CARRIES: assert (c_local) else $error("slice generate without carry out"); // R3
    end
    if (g_n && p_n) begin
      AST_SLICE_KILL_BLOCKS: assert (!c_local) else $error("slice blocks carry but carry out set"); // R4
    end
  end

endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4
  import cla_pkg::*;
#(
  parameter int NG = GROUPS_N
) (
  input  logic [NG-1:0] g_n,
  input  logic [NG-1:0] p_n,
  input  logic          cin,
  output logic [NG-2:0] c_grp,
  output logic          bg_n,
  output logic          bp_n
);

  logic [NG-1:0] g;
  logic [NG-1:0] p;

  assign g = ~g_n;
  assign p = ~p_n;

  // Carries into groups 1..NG-1, flat sums of products in true polarity.
  always_comb begin
    logic acc;
    logic term;
    for (int i = 1; i < NG; i++) begin
      term = cin;
      for (int k = 0; k < i; k++) term = term & p[k];
      acc = term;
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        acc = acc | term;
      end
      c_grp[i-1] = acc;
    end
  end

  // Block flags across all groups, driven active low.
  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < NG; j++) begin
      term = g[j];
      for (int k = j + 1; k < NG; k++) term = term & p[k];
      acc = acc | term;
    end
    bg_n = ~acc;
    bp_n = ~(&p);
  end

  always_comb begin
    if (!g_n[0]) begin
      AST_LA_GEN0_CARRY: assert (c_grp[0]) else $error("group 0 generate did not carry"); // R8
    end
    if (!bp_n && (&g_n)) begin
      AST_LA_PASS_THROUGH: assert (c_grp == {(NG-1){cin}}) else $error("propagate path lost carry-in"); // R4
    end
    if (!bg_n) begin
      AST_LA_BLOCK_GEN: assert (!(&g_n)) else $error("block generate with no group generate"); // R3
    end
  end

endmodule

// File: rtl/cla_section.sv
module cla_section
  import cla_pkg::*;
#(
  parameter int NUM_SLICES = GROUPS_N,
  localparam int SW = SLICE_W * NUM_SLICES
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  output logic [SW-1:0] sum,
  output grp_pg_t       pg,
  output logic          cout
);

  logic [GROUPS_N-1:0] grp_g_n;
  logic [GROUPS_N-1:0] grp_p_n;
  logic [GROUPS_N-2:0] c_grp;
  logic [GROUPS_N-1:0] c_in_vec;
  logic [NUM_SLICES-1:0] c_local;
  logic bg_n;
  logic bp_n;

  assign c_in_vec = {c_grp, cin};

  genvar i;
  for (i = 0; i < GROUPS_N; i++) begin : g_pos
    if (i < NUM_SLICES) begin : g_real
      cla_slice4 #(.W(SLICE_W)) u_slice (
        .a       (a[i*SLICE_W +: SLICE_W]),
        .b       (b[i*SLICE_W +: SLICE_W]),
        .cin     (c_in_vec[i]),
        .sum     (sum[i*SLICE_W +: SLICE_W]),
        .g_n     (grp_g_n[i]),
        .p_n     (grp_p_n[i]),
        .c_local (c_local[i])
      );
    end else begin : g_pad
      // Missing group: never generates, always passes a carry on.
      assign grp_g_n[i] = 1'b1;
      assign grp_p_n[i] = 1'b0;
    end
  end

  cla_lookahead4 #(.NG(GROUPS_N)) u_la (
    .g_n   (grp_g_n),
    .p_n   (grp_p_n),
    .cin   (cin),
    .c_grp (c_grp),
    .bg_n  (bg_n),
    .bp_n  (bp_n)
  );

  assign pg.g_n = bg_n;
  assign pg.p_n = bp_n;
  assign cout   = (~bg_n) | ((~bp_n) & cin);

  for (i = 0; i < NUM_SLICES - 1; i++) begin : g_chk
    always_comb begin
      AST_LA_MATCHES_RIPPLE: assert (c_grp[i] == c_local[i]) else $error("lookahead carry differs from slice ripple"); // R8
    end
  end

  always_comb begin
    AST_SECT_COUT_MATCH: assert (cout == c_local[NUM_SLICES-1]) else $error("section carry-out mismatch"); // R8
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             blk_g_n,
  output logic             blk_p_n
);

  localparam int NSLICE = WIDTH / SLICE_W;
  localparam int NSECT  = (NSLICE + GROUPS_N - 1) / GROUPS_N;

  if ((WIDTH % SLICE_W) != 0 || WIDTH < SLICE_W) begin : g_bad_width
    $error("cla_adder: WIDTH must be a positive multiple of 4"); // R9
  end

  logic    [NSECT:0] sec_c;
  grp_pg_t           chain_pg [NSECT+1];
  grp_pg_t           sec_pg   [NSECT];

  assign sec_c[0]    = cin;
  assign chain_pg[0] = PG_IDENTITY;

  genvar s;
  for (s = 0; s < NSECT; s++) begin : g_sect
    localparam int NS = ((NSLICE - s*GROUPS_N) > GROUPS_N) ? GROUPS_N : (NSLICE - s*GROUPS_N);
    localparam int LO = s * SECTION_W;

    cla_section #(.NUM_SLICES(NS)) u_sect (
      .a    (a[LO +: NS*SLICE_W]),
      .b    (b[LO +: NS*SLICE_W]),
      .cin  (sec_c[s]),
      .sum  (sum[LO +: NS*SLICE_W]),
      .pg   (sec_pg[s]),
      .cout (sec_c[s+1])
    );

    assign chain_pg[s+1] = pg_merge(sec_pg[s], chain_pg[s]);
  end

  assign cout    = sec_c[NSECT];
  assign blk_g_n = chain_pg[NSECT].g_n;
  assign blk_p_n = chain_pg[NSECT].p_n;

  always_comb begin
    AST_COUT_FROM_FLAGS: assert (cout == ((!blk_g_n) | ((!blk_p_n) & cin))) else $error("carry-out disagrees with block flags"); // R5
    if (!blk_g_n) begin
      AST_GEN_FORCES_COUT: assert (cout) else $error("block generate without carry-out"); // R3
    end
  end

endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a32, b32;
  logic        cin;
  logic [31:0] sum32;
  logic        cout32, g32_n, p32_n;
  logic [27:0] sum28;
  logic        cout28, g28_n, p28_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  cla_adder #(.WIDTH(32)) dut (
    .a(a32), .b(b32), .cin(cin),
    .sum(sum32), .cout(cout32), .blk_g_n(g32_n), .blk_p_n(p32_n)
  );

  cla_adder #(.WIDTH(28)) dut_w28 (
    .a(a32[27:0]), .b(b32[27:0]), .cin(cin),
    .sum(sum28), .cout(cout28), .blk_g_n(g28_n), .blk_p_n(p28_n)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (a=%h b=%h cin=%0d)", req, what, act, exp, a32, b32, cin);
    end
  endtask

  // Behavioural reference for one width.
  task automatic compare(input int w, input longint s_act, input longint c_act,
                         input longint g_act, input longint p_act, input string tag);
    longint mask, av, bv, full, nc;
    mask = (64'sd1 <<< w) - 1;
    av   = longint'(a32) & mask;
    bv   = longint'(b32) & mask;
    full = av + bv + longint'(cin);
    nc   = av + bv;
    check(w == 28 ? "R1/R7" : "R1", {tag, " sum"}, s_act, full & mask);
    check(w == 28 ? "R2/R7" : "R2", {tag, " cout"}, c_act, (full >> w) & 1);
    check("R3", {tag, " blk_g_n"}, g_act, ((nc >> w) & 1) ? 0 : 1);
    check("R4", {tag, " blk_p_n"}, p_act, ((av | bv) == mask) ? 0 : 1);
    check("R5", {tag, " cout vs flags"}, c_act,
          longint'((g_act == 0) || ((p_act == 0) && cin)));
  endtask

  task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic ci);
    @(posedge clk);
    #1;
    a32 = av; b32 = bv; cin = ci;
    @(negedge clk);
    compare(32, sum32, cout32, g32_n, p32_n, "w32");
    compare(28, sum28, cout28, g28_n, p28_n, "w28");
  endtask

  initial begin
    a32 = '0; b32 = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset-time state: zero inputs give zero sum and inactive flags. R1 R3 R4
    check("R1", "reset sum", sum32, 0);
    check("R3", "reset blk_g_n", g32_n, 1);
    check("R4", "reset blk_p_n", p32_n, 1);
    rst_n = 1'b1;

    apply(32'h0, 32'h0, 1'b0);                       // zero plus zero
    apply(32'hFFFF_FFFF, 32'h0, 1'b1);               // all ones plus carry-in
    apply(32'hFFFF_FFFF, 32'h1, 1'b0);               // all ones plus one
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);       // alternating, full propagate
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
    apply(32'h5555_5555, 32'h5555_5555, 1'b1);
    apply(32'h0000_FFFF, 32'h0000_0001, 1'b0);       // R6 section crossing
    check("R6", "carry into upper section", sum32, 32'h0001_0000);
    apply(32'h0000_FFFF, 32'h0000_0000, 1'b1);       // R6 via carry-in
    check("R6", "carry-in into upper section", sum32, 32'h0001_0000);
    apply(32'h0FFF_FFFF, 32'h0000_0001, 1'b0);       // R7 boundary of 28-bit word
    check("R7", "w28 cout at bit 28", cout28, 1);
    apply(32'h0000_000F, 32'h0000_0001, 1'b0);       // R8 slice boundary
    apply(32'h000F_FFF0, 32'h0000_0010, 1'b0);       // R8 ripple through slices
    apply(32'h8000_0000, 32'h8000_0000, 1'b0);       // top generate only
    for (int k = 0; k < 8; k++) begin
      apply(32'hF << (4*k), 32'h1 << (4*k), 1'b0);   // R8 each slice generates
    end
    for (int k = 0; k < 400; k++) begin
      apply($urandom, $urandom, 1'($urandom));
    end
    for (int k = 0; k < 100; k++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r, ~r, 1'($urandom));                    // full propagate pattern
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule